// File: doc/BRIEF.md
# Flash Program/Erase Suspend Controller

This block runs the handshake that pauses or continues a program or erase operation inside a serial flash device. A one-cycle start pulse selects either a pause (suspend) or a continue (resume) operation. The block then asks a downstream SPI phase sequencer to send the matching 8-bit opcode. It can hold off for a programmable number of SPI clock ticks, and then it keeps reading the flash status register until the device reports the target state.

Each status read is judged in two parts. The first is the busy (write-in-progress) bit. The second is a set of suspend-state bits, found by XOR of the returned status with a 16-bit mask. A poll count limit stops a device that never reports its suspend bits: once the limit is reached, the check counts as passed. Two things happen when an operation completes: a one-cycle end event fires, and a sticky suspended flag is updated. A suspend can also be set to start a resume by itself as soon as it finishes.

Transfers use a plain request/done handshake. The block holds `txnReq` with stable opcode, opcode length and read-byte count. The sequencer answers with a one-cycle `txnDone` and, for reads, the status bytes.

Top module: `flash_susp_ctrl`

## Requirements
- R1: After reset, `txnReq`, both busy outputs, `suspended` and both end pulses are 0.
- R2: A start pulse while no operation runs raises the matching busy output on the next cycle. The block then requests an opcode transfer with `txnCmd` = the programmable suspend or resume opcode (zero-extended), `txnCmdLen` = 8 and `txnRdBytes` = 0. `txnReq` and its fields stay stable until `txnDone`.
- R3: If the operation's wait enable is set, the status poll starts after `delayField`×4 SPI ticks, or `delayField`×128 SPI ticks when the operation's long-wait bit is set. The block is idle for that count plus one cycle when `spiTick` is always high. If the wait enable is clear, the poll request follows the opcode transfer with no idle cycle.
- R4: A status poll sends all 16 bits of `pollCmd` with `txnCmdLen` = 16 when `pollCmdWide` = 1. Otherwise it sends `pollCmd[7:0]` with length 8. It reads 2 bytes when `pollTwoBytes` = 1 and 1 byte otherwise.
- R5: Bit 0 of the returned status is write-in-progress. While that bit is 1, the block polls again.
- R6: The suspend bits are (status XOR `statusMask`), with bits 15:8 forced to 0 when one byte is read. A suspend matches when any of these bits is 1. A resume matches when all of them are 0. When the operation's check enable is 0, a clear write-in-progress bit alone completes the operation.
- R7: Each poll that has write-in-progress clear but fails the suspend-bit match counts as a failure. The poll on which the failure count reaches `retryLimit` is treated as a pass.
- R8: A finished suspend pulses `suspEndPulse` for one cycle and sets `suspended`. A finished resume pulses `resumeEndPulse` and clears `suspended`.
- R9: With `chainResume` = 1, a finished suspend starts a resume operation at once, with no new start pulse.
- R10: A busy output clears itself when its operation ends. Start pulses that arrive while an operation runs are ignored. If both starts arrive together while idle, the suspend is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| suspStart | input | 1 | Start a suspend operation (pulse) |
| resumeStart | input | 1 | Start a resume operation (pulse) |
| suspCmd | input | 8 | Suspend opcode |
| resumeCmd | input | 8 | Resume opcode |
| pollCmd | input | 16 | Status read opcode |
| pollCmdWide | input | 1 | 1: send 16-bit poll opcode |
| pollTwoBytes | input | 1 | 1: poll reads two status bytes |
| statusMask | input | 16 | XOR mask applied to the status |
| suspCheckEn | input | 1 | Suspend also needs the suspend bits to match |
| resumeCheckEn | input | 1 | Resume also needs the suspend bits to match |
| retryLimit | input | 7 | Failed suspend-bit checks counted as a pass |
| chainResume | input | 1 | Start a resume automatically after a suspend |
| delayField | input | 10 | Post-opcode wait base count |
| suspWaitEn | input | 1 | Wait after the suspend opcode |
| resumeWaitEn | input | 1 | Wait after the resume opcode |
| suspWaitLong | input | 1 | Suspend wait multiplier 128 instead of 4 |
| resumeWaitLong | input | 1 | Resume wait multiplier 128 instead of 4 |
| spiTick | input | 1 | One pulse per SPI clock period |
| txnReq | output | 1 | Transfer request to the sequencer |
| txnCmd | output | 16 | Opcode to send |
| txnCmdLen | output | 5 | Opcode length in bits (8 or 16) |
| txnRdBytes | output | 2 | Status bytes to read (0, 1 or 2) |
| txnDone | input | 1 | Transfer finished (pulse) |
| txnRdData | input | 16 | Status read back, valid with txnDone |
| suspBusy | output | 1 | Suspend request pending |
| resumeBusy | output | 1 | Resume request pending |
| suspended | output | 1 | Flash is held in the suspended state |
| suspEndPulse | output | 1 | Suspend finished event |
| resumeEndPulse | output | 1 | Resume finished event |

## Verification
The assertions assume a well-behaved sequencer: it pulses `txnDone` only while `txnReq` is high, and only once per request. They also assume the configuration inputs, `retryLimit` in particular, stay fixed while an operation runs. The bench's responder raises `txnDone` only two cycles after it sees a request, and holds it for one cycle. The bench changes configuration only when both busy outputs are low, and it ties `spiTick` high so that wait lengths are exact cycle counts.

// File: rtl/fsusp_pkg.sv
package fsusp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_WAIT = 2'd2,
    ST_POLL = 2'd3
  } fsuspState_t;

  typedef struct packed {
    logic loadDelay;
    logic clrFail;
    logic incFail;
  } dpStrobe_t;
endpackage

// File: rtl/fsusp_dpath.sv
module fsusp_dpath
  import fsusp_pkg::*;
#(
  parameter int DLY_W       = 10,
  parameter int RETRY_W     = 7,
  parameter int STAT_W      = 16,
  parameter int SHORT_SHIFT = 2,
  parameter int LONG_SHIFT  = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strb,
  input  logic               opResume,
  input  logic               spiTick,
  input  logic [DLY_W-1:0]   delayField,
  input  logic               longMul,
  input  logic [STAT_W-1:0]  rdData,
  input  logic               twoBytes,
  input  logic [STAT_W-1:0]  statusMask,
  input  logic [RETRY_W-1:0] retryLimit,
  output logic               delayDone,
  output logic               wipBusy,
  output logic               bitsMatch,
  output logic               retryExhaust
);
  localparam int CNT_W  = DLY_W + LONG_SHIFT;
  localparam int BYTE_W = STAT_W / 2;

  logic [CNT_W-1:0]   delayCnt;
  logic [RETRY_W-1:0] failCnt;
  logic [STAT_W-1:0]  validMask;
  logic [STAT_W-1:0]  susBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      delayCnt <= '0;
    end else if (strb.loadDelay) begin
      delayCnt <= longMul ? (CNT_W'(delayField) << LONG_SHIFT)
                          : (CNT_W'(delayField) << SHORT_SHIFT);
    end else if (spiTick && delayCnt != '0) begin
      delayCnt <= delayCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failCnt <= '0;
    end else if (strb.clrFail) begin
      failCnt <= '0;
    end else if (strb.incFail) begin
      failCnt <= failCnt + 1'b1;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < STAT_W; gi++) begin : g_valid
      if (gi < BYTE_W) begin : g_low
        assign validMask[gi] = 1'b1;
      end else begin : g_high
        assign validMask[gi] = twoBytes;
      end
    end
  endgenerate

  assign susBits      = (rdData ^ statusMask) & validMask;
  assign bitsMatch    = opResume ? (susBits == '0) : (susBits != '0);
  assign wipBusy      = rdData[0];
  assign delayDone    = (delayCnt == '0);
  assign retryExhaust = ({1'b0, failCnt} + 1'b1) >= {1'b0, retryLimit};

  // R7: a failure is only counted while the limit is still ahead
  assert_fail_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.incFail |-> (({1'b0, failCnt} + 1'b1) < {1'b0, retryLimit}));

  // R3: the wait counter only ever moves down between loads
  assert_delay_down_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadDelay && delayCnt != '0 |=> delayCnt <= $past(delayCnt));
endmodule

// File: rtl/fsusp_ctrl.sv
module fsusp_ctrl
  import fsusp_pkg::*;
#(
  parameter int CMD_W  = 8,
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              suspStart,
  input  logic              resumeStart,
  input  logic [CMD_W-1:0]  suspCmd,
  input  logic [CMD_W-1:0]  resumeCmd,
  input  logic [STAT_W-1:0] pollCmd,
  input  logic              pollCmdWide,
  input  logic              pollTwoBytes,
  input  logic              suspCheckEn,
  input  logic              resumeCheckEn,
  input  logic              chainResume,
  input  logic              suspWaitEn,
  input  logic              resumeWaitEn,
  input  logic              txnDone,
  input  logic              delayDone,
  input  logic              wipBusy,
  input  logic              bitsMatch,
  input  logic              retryExhaust,
  output dpStrobe_t         strb,
  output logic              opResume,
  output logic              txnReq,
  output logic [STAT_W-1:0] txnCmd,
  output logic [4:0]        txnCmdLen,
  output logic [1:0]        txnRdBytes,
  output logic              suspBusy,
  output logic              resumeBusy,
  output logic              suspended,
  output logic              suspEndPulse,
  output logic              resumeEndPulse
);
  fsuspState_t state;
  logic waitEn, checkEn, pollPass;

  assign waitEn   = opResume ? resumeWaitEn : suspWaitEn;
  assign checkEn  = opResume ? resumeCheckEn : suspCheckEn;
  assign pollPass = !wipBusy && (!checkEn || bitsMatch || retryExhaust);

  always_comb begin
    strb       = '0;
    txnReq     = 1'b0;
    txnCmd     = '0;
    txnCmdLen  = 5'd0;
    txnRdBytes = 2'd0;
    case (state)
      ST_CMD: begin
        txnReq    = 1'b1;
        txnCmd    = STAT_W'(opResume ? resumeCmd : suspCmd);
        txnCmdLen = 5'(CMD_W);
        strb.clrFail   = txnDone;
        strb.loadDelay = txnDone && waitEn;
      end
      ST_POLL: begin
        txnReq     = 1'b1;
        txnCmd     = pollCmdWide ? pollCmd : {{(STAT_W-8){1'b0}}, pollCmd[7:0]};
        txnCmdLen  = pollCmdWide ? 5'd16 : 5'd8;
        txnRdBytes = pollTwoBytes ? 2'd2 : 2'd1;
        strb.incFail = txnDone && !wipBusy && checkEn && !bitsMatch && !retryExhaust;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state          <= ST_IDLE;
      opResume       <= 1'b0;
      suspBusy       <= 1'b0;
      resumeBusy     <= 1'b0;
      suspended      <= 1'b0;
      suspEndPulse   <= 1'b0;
      resumeEndPulse <= 1'b0;
    end else begin
      suspEndPulse   <= 1'b0;
      resumeEndPulse <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (suspStart) begin
            opResume <= 1'b0;
            suspBusy <= 1'b1;
            state    <= ST_CMD;
          end else if (resumeStart) begin
            opResume   <= 1'b1;
            resumeBusy <= 1'b1;
            state      <= ST_CMD;
          end
        end
        ST_CMD: if (txnDone) state <= waitEn ? ST_WAIT : ST_POLL;
        ST_WAIT: if (delayDone) state <= ST_POLL;
        ST_POLL: begin
          if (txnDone && pollPass) begin
            if (!opResume) begin
              suspEndPulse <= 1'b1;
              suspended    <= 1'b1;
              suspBusy     <= 1'b0;
              if (chainResume) begin
                opResume   <= 1'b1;
                resumeBusy <= 1'b1;
                state      <= ST_CMD;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              resumeEndPulse <= 1'b1;
              suspended      <= 1'b0;
              resumeBusy     <= 1'b0;
              state          <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_busy_onehot_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({suspBusy, resumeBusy}));

  assert_req_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    txnReq && !txnDone |=> txnReq && $stable(txnCmd) && $stable(txnRdBytes));

  assert_susp_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    suspEndPulse |-> suspended);

  assert_resume_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    resumeEndPulse |-> !suspended);

  assert_chain_R9: assert property (@(posedge clk) disable iff (!rstN)
    suspEndPulse && chainResume |-> resumeBusy);
endmodule

// File: rtl/flash_susp_ctrl.sv
module flash_susp_ctrl
  import fsusp_pkg::*;
#(
  parameter int CMD_W   = 8,
  parameter int STAT_W  = 16,
  parameter int DLY_W   = 10,
  parameter int RETRY_W = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               suspStart,
  input  logic               resumeStart,
  input  logic [CMD_W-1:0]   suspCmd,
  input  logic [CMD_W-1:0]   resumeCmd,
  input  logic [STAT_W-1:0]  pollCmd,
  input  logic               pollCmdWide,
  input  logic               pollTwoBytes,
  input  logic [STAT_W-1:0]  statusMask,
  input  logic               suspCheckEn,
  input  logic               resumeCheckEn,
  input  logic [RETRY_W-1:0] retryLimit,
  input  logic               chainResume,
  input  logic [DLY_W-1:0]   delayField,
  input  logic               suspWaitEn,
  input  logic               resumeWaitEn,
  input  logic               suspWaitLong,
  input  logic               resumeWaitLong,
  input  logic               spiTick,
  output logic               txnReq,
  output logic [STAT_W-1:0]  txnCmd,
  output logic [4:0]         txnCmdLen,
  output logic [1:0]         txnRdBytes,
  input  logic               txnDone,
  input  logic [STAT_W-1:0]  txnRdData,
  output logic               suspBusy,
  output logic               resumeBusy,
  output logic               suspended,
  output logic               suspEndPulse,
  output logic               resumeEndPulse
);
  dpStrobe_t strb;
  logic opResume, delayDone, wipBusy, bitsMatch, retryExhaust;

  fsusp_ctrl #(.CMD_W(CMD_W), .STAT_W(STAT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .suspStart(suspStart), .resumeStart(resumeStart),
    .suspCmd(suspCmd), .resumeCmd(resumeCmd), .pollCmd(pollCmd),
    .pollCmdWide(pollCmdWide), .pollTwoBytes(pollTwoBytes),
    .suspCheckEn(suspCheckEn), .resumeCheckEn(resumeCheckEn),
    .chainResume(chainResume), .suspWaitEn(suspWaitEn), .resumeWaitEn(resumeWaitEn),
    .txnDone(txnDone), .delayDone(delayDone), .wipBusy(wipBusy),
    .bitsMatch(bitsMatch), .retryExhaust(retryExhaust), .strb(strb),
    .opResume(opResume), .txnReq(txnReq), .txnCmd(txnCmd), .txnCmdLen(txnCmdLen),
    .txnRdBytes(txnRdBytes), .suspBusy(suspBusy), .resumeBusy(resumeBusy),
    .suspended(suspended), .suspEndPulse(suspEndPulse), .resumeEndPulse(resumeEndPulse)
  );

  fsusp_dpath #(.DLY_W(DLY_W), .RETRY_W(RETRY_W), .STAT_W(STAT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .opResume(opResume), .spiTick(spiTick),
    .delayField(delayField), .longMul(opResume ? resumeWaitLong : suspWaitLong),
    .rdData(txnRdData), .twoBytes(pollTwoBytes), .statusMask(statusMask),
    .retryLimit(retryLimit), .delayDone(delayDone), .wipBusy(wipBusy),
    .bitsMatch(bitsMatch), .retryExhaust(retryExhaust)
  );
endmodule

// File: tb/flash_susp_ctrl_bench.sv
module flash_susp_ctrl_bench;
  logic clk = 1'b0, rstN = 1'b0;
  logic suspStart = 0, resumeStart = 0;
  logic [7:0] suspCmd = 8'h75, resumeCmd = 8'h7A;
  logic [15:0] pollCmd = 16'h3505, statusMask = 16'h0;
  logic pollCmdWide = 0, pollTwoBytes = 0, suspCheckEn = 1, resumeCheckEn = 1;
  logic [6:0] retryLimit = 7'd10;
  logic chainResume = 0;
  logic [9:0] delayField = 10'd0;
  logic suspWaitEn = 0, resumeWaitEn = 0, suspWaitLong = 0, resumeWaitLong = 0;
  logic spiTick = 1'b1;
  logic txnReq, txnDone = 0;
  logic [15:0] txnCmd, txnRdData = 16'h0;
  logic [4:0] txnCmdLen;
  logic [1:0] txnRdBytes;
  logic suspBusy, resumeBusy, suspended, suspEndPulse, resumeEndPulse;

  flash_susp_ctrl u_flash_susp_ctrl (.*);

  always #10 clk = ~clk;

  int nChecks = 0, nFails = 0, suspEvts = 0, resumeEvts = 0, idleCnt = 0;
  logic [15:0] qCmd[$], qRsp[$];
  logic [4:0]  qLen[$];
  logic [1:0]  qNb[$];
  int          qGap[$];
  string       qTag[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expTxn(input logic [15:0] cmd, input logic [4:0] len, input logic [1:0] nb,
                        input int gap, input logic [15:0] rsp, input string tag);
    qCmd.push_back(cmd); qLen.push_back(len); qNb.push_back(nb);
    qGap.push_back(gap); qRsp.push_back(rsp); qTag.push_back(tag);
  endtask

  // monitor / responder: pops expected transfers and answers them
  initial begin
    @(negedge clk);
    forever begin
      if (rstN && txnReq) begin
        logic [15:0] rsp;
        rsp = 16'h0;
        if (qCmd.size() == 0) begin
          check(1'b0, "R2 unexpected transfer", int'(txnCmd), 0);
        end else begin
          string tg;
          int g;
          tg = qTag.pop_front();
          g = qGap.pop_front();
          rsp = qRsp.pop_front();
          check(txnCmd == qCmd[0], {tg, " cmd"}, int'(txnCmd), int'(qCmd[0]));
          check(txnCmdLen == qLen[0], {tg, " len"}, int'(txnCmdLen), int'(qLen[0]));
          check(txnRdBytes == qNb[0], {tg, " bytes"}, int'(txnRdBytes), int'(qNb[0]));
          if (g >= 0) check(idleCnt == g, {tg, " gap"}, idleCnt, g);
          void'(qCmd.pop_front()); void'(qLen.pop_front()); void'(qNb.pop_front());
        end
        repeat (2) @(negedge clk);
        txnRdData = rsp;
        txnDone = 1'b1;
        @(negedge clk);
        txnDone = 1'b0;
        idleCnt = 0;
      end else begin
        idleCnt++;
        @(negedge clk);
      end
    end
  end

  always @(negedge clk) begin
    if (suspEndPulse) suspEvts++;
    if (resumeEndPulse) resumeEvts++;
  end

  task automatic pulse(input bit s, input bit r);
    @(negedge clk);
    suspStart = s; resumeStart = r;
    @(negedge clk);
    suspStart = 0; resumeStart = 0;
  endtask

  task automatic finish();
    @(negedge clk);
    while (suspBusy || resumeBusy) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    check(qCmd.size() == 0, "R7 all expected transfers seen", qCmd.size(), 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int s0, r0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!txnReq && !suspBusy && !resumeBusy && !suspended && !suspEndPulse && !resumeEndPulse,
          "R1 reset outputs", {txnReq, suspBusy, resumeBusy, suspended}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2/R4/R5/R6: suspend, 8-bit poll, one busy read then mask makes bit 7 set
    statusMask = 16'h0080;
    expTxn(16'h0075, 5'd8, 2'd0, -1, 16'h0, "R2 suspend opcode");
    expTxn(16'h0005, 5'd8, 2'd1, 0, 16'h0001, "R4 poll short");
    expTxn(16'h0005, 5'd8, 2'd1, 0, 16'h0000, "R5 repoll on WIP");
    pulse(1, 0);
    check(suspBusy, "R2 busy raised", suspBusy, 1);
    finish();
    check(suspended && suspEvts == 1, "R8 suspend end", suspEvts, 1);
    check(!suspBusy, "R10 busy self-clear", suspBusy, 0);

    // R3/R4/R6: resume with x4 wait, wide poll, two bytes, upper byte mismatch once
    statusMask = 16'h0; pollCmdWide = 1; pollTwoBytes = 1;
    resumeWaitEn = 1; delayField = 10'd3;
    expTxn(16'h007A, 5'd8, 2'd0, -1, 16'h0, "R2 resume opcode");
    expTxn(16'h3505, 5'd16, 2'd2, 13, 16'h0100, "R3 short wait");
    expTxn(16'h3505, 5'd16, 2'd2, 0, 16'h0000, "R6 resume retry");
    pulse(0, 1);
    finish();
    check(!suspended && resumeEvts == 1, "R8 resume end", resumeEvts, 1);

    // R6/R7: one byte read hides upper byte; limit 3 passes on third failure
    pollCmdWide = 0; pollTwoBytes = 0; retryLimit = 7'd3; resumeWaitEn = 0;
    expTxn(16'h0075, 5'd8, 2'd0, -1, 16'h0, "R2 suspend opcode");
    expTxn(16'h0005, 5'd8, 2'd1, 0, 16'hFF00, "R6 upper byte ignored 1");
    expTxn(16'h0005, 5'd8, 2'd1, 0, 16'hFF00, "R7 retry 2");
    expTxn(16'h0005, 5'd8, 2'd1, 0, 16'hFF00, "R7 retry 3 passes");
    pulse(1, 0);
    finish();
    check(suspended && suspEvts == 2, "R7 limit pass", suspEvts, 2);

    // R6: resume check disabled, custom opcode
    resumeCheckEn = 0; resumeCmd = 8'hAB;
    expTxn(16'h00AB, 5'd8, 2'd0, -1, 16'h0, "R2 custom resume opcode");
    expTxn(16'h0005, 5'd8, 2'd1, 0, 16'h00FE, "R6 check off");
    pulse(0, 1);
    finish();
    check(!suspended && resumeEvts == 2, "R6 WIP alone ends resume", resumeEvts, 2);

    // R3: long wait 1 x 128
    resumeCheckEn = 1; resumeCmd = 8'h7A;
    suspWaitEn = 1; suspWaitLong = 1; delayField = 10'd1;
    expTxn(16'h0075, 5'd8, 2'd0, -1, 16'h0, "R2 suspend opcode");
    expTxn(16'h0005, 5'd8, 2'd1, 129, 16'h0002, "R3 long wait");
    pulse(1, 0);
    finish();
    check(suspended, "R3 suspend after long wait", suspended, 1);

    // R9: chained resume
    suspWaitEn = 0; chainResume = 1;
    s0 = suspEvts; r0 = resumeEvts;
    expTxn(16'h0075, 5'd8, 2'd0, -1, 16'h0, "R9 suspend opcode");
    expTxn(16'h0005, 5'd8, 2'd1, 0, 16'h0002, "R9 suspend poll");
    expTxn(16'h007A, 5'd8, 2'd0, -1, 16'h0, "R9 chained resume opcode");
    expTxn(16'h0005, 5'd8, 2'd1, 0, 16'h0000, "R9 resume poll");
    pulse(1, 0);
    finish();
    check(suspEvts == s0 + 1 && resumeEvts == r0 + 1 && !suspended, "R9 chain events",
          resumeEvts - r0, 1);

    // R10: simultaneous starts take suspend; starts while busy ignored
    chainResume = 0;
    s0 = suspEvts; r0 = resumeEvts;
    expTxn(16'h0075, 5'd8, 2'd0, -1, 16'h0, "R10 suspend wins");
    expTxn(16'h0005, 5'd8, 2'd1, 0, 16'h0001, "R10 busy poll");
    expTxn(16'h0005, 5'd8, 2'd1, 0, 16'h0002, "R10 done poll");
    pulse(1, 1);
    check(suspBusy && !resumeBusy, "R10 priority", {suspBusy, resumeBusy}, 2);
    pulse(0, 1);
    check(!resumeBusy, "R10 resume ignored while busy", resumeBusy, 0);
    pulse(1, 0);
    finish();
    check(suspEvts == s0 + 1 && resumeEvts == r0, "R10 only one operation",
          suspEvts - s0, 1);

    summary();
  end
endmodule